// File: doc/BRIEF.md
# Half-Aligned Instruction Fetch with Slot Kill Mask

This block is the front end of a dual-slot instruction fetch path. The instruction memory is organised in blocks, and every read returns exactly one aligned half of a block: either the lower half or the upper half. The unit holds a fetch PC and turns it into one half-aligned memory request per cycle. When the PC lands partway into a half, for example on a branch target, the words that precede it are still read but are marked dead. Words that follow a taken branch in the same half are also marked dead. Each dead slot travels down the pipe as a bubble.

A group of instructions that runs past the end of an aligned half can never come back from one access. The remaining words are read by the next sequential request, one cycle later. Branch prediction is outside the block. A taken-branch indication, with its slot and its target, arrives as an input together with the request it belongs to. A separate redirect input from later stages flushes the bundles in flight and restarts fetch. A stall input freezes the whole unit. The memory has one cycle of read latency, and the bundle it returns is registered before it leaves the block.

Top module: `half_fetch_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is all zero and the request points at the half containing `RESET_PC`.
- R2: The memory request always names one aligned half. `mem_block` carries the PC bits above the half-select bit. `mem_upper` is PC bit `OFF_W` (bit 3 by default), where 0 means the lower half and 1 the upper half.
- R3: For a half-aligned PC with no taken branch, both slots come out valid. `out_pc` equals the half base, and slot i of `out_insn` (bits `i*INSN_W +: INSN_W`) holds the word at byte address `out_pc + 4*i`.
- R4: Slot i is killed when its address lies before the fetch PC. The slot index is PC bits [OFF_W-1:2].
- R5: Without stall, redirect or taken branch, the next request is the following aligned half (base + 8). A target in slot 1 therefore yields one live slot, and the next slot follows one cycle later.
- R6: A taken branch at slot `br_slot` kills every later slot of its half, and the next request is the aligned half that contains `br_target`.
- R7: A redirect makes the next request address the half containing `redirect_pc`. The bundle leaving the block one cycle later has `out_valid` zero, as does the bundle after it. A redirect takes priority over stall and over a taken branch.
- R8: While `stall` is high and there is no redirect, `mem_en` is low, the request address is unchanged, and `out_valid`, `out_pc` and `out_insn` hold.
- R9: A request issued in cycle t with `mem_en` high appears at the outputs from cycle t+2 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freeze PC, in-flight request and output bundle |
| redirect_valid | input | 1 | Flush the bundles in flight and restart at `redirect_pc` |
| redirect_pc | input | 32 | Restart address |
| br_taken | input | 1 | The request issued this cycle holds a taken branch |
| br_slot | input | SLOT_W (1) | Slot of the taken branch within the half |
| br_target | input | 32 | Target of the taken branch |
| mem_en | output | 1 | Memory read enable |
| mem_block | output | ADDR_W-OFF_W-1 (28) | Block index of the request |
| mem_upper | output | 1 | Half select: 0 lower, 1 upper |
| mem_rdata | input | SLOTS*INSN_W (64) | Half returned one cycle after an enabled read, slot 0 in the low bits |
| out_valid | output | SLOTS (2) | Per-slot live bit of the bundle |
| out_pc | output | 32 | Half-aligned address of the bundle |
| out_insn | output | SLOTS*INSN_W (64) | Instruction words of the bundle |

## Verification
The bench builds the block with its default parameters: four-byte words, two slots per half, and a reset PC of 0x100. With these values every slot position, the half-select bit, and lower-to-upper and upper-to-next-block crossings all occur within a few dozen cycles. The stimulus lands branch targets and redirects in slot 1 and puts a taken branch in each slot. It also raises a stall across an in-flight read and a redirect during a stall. These reach the kill cases before and after the PC, the extra cycle for a split group, and the hold of the read data while the unit is frozen.

// File: rtl/half_fetch_pkg.sv
package half_fetch_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  // Clear the byte offset within a half.
  function automatic addr_t half_base(addr_t pc, int off_w);
    addr_t keep;
    keep = '1;
    keep = keep << off_w;
    return pc & keep;
  endfunction

  // Start of the aligned half that follows the one containing pc.
  function automatic addr_t next_half(addr_t pc, int off_w);
    return half_base(pc, off_w) + (addr_t'(1) << off_w);
  endfunction
endpackage

// File: rtl/fetch_pc_gen.sv
module fetch_pc_gen
  import half_fetch_pkg::*;
#(
  parameter int    OFF_W    = 3,
  parameter addr_t RESET_PC = 32'h0000_0100
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stall,
  input  logic  redirect_valid,
  input  addr_t redirect_pc,
  input  logic  br_taken,
  input  addr_t br_target,
  output addr_t fetch_pc,
  output addr_t seq_pc
);
  assign seq_pc = next_half(fetch_pc, OFF_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
    end else if (redirect_valid) begin
      fetch_pc <= redirect_pc;
    end else if (!stall) begin
      fetch_pc <= br_taken ? br_target : seq_pc;
    end
  end
endmodule

// File: rtl/fetch_slot_mask.sv
module fetch_slot_mask #(
  parameter int SLOTS  = 2,
  parameter int SLOT_W = 1
) (
  input  logic [SLOT_W-1:0] start_slot,
  input  logic              br_taken,
  input  logic [SLOT_W-1:0] br_slot,
  output logic [SLOTS-1:0]  live
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic at_or_after_pc;
    logic before_branch;
    assign at_or_after_pc = SLOT_W'(i) >= start_slot;
    assign before_branch  = !br_taken || (SLOT_W'(i) <= br_slot);
    assign live[i]        = at_or_after_pc && before_branch;
  end
endmodule

// File: rtl/fetch_stage_regs.sv
module fetch_stage_regs
  import half_fetch_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int INSN_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    flush,
  input  addr_t                   req_base,
  input  logic [SLOTS-1:0]        req_live,
  input  logic [SLOTS*INSN_W-1:0] rsp_data,
  output logic [SLOTS-1:0]        out_valid,
  output addr_t                   out_pc,
  output logic [SLOTS*INSN_W-1:0] out_insn
);
  addr_t            inflight_base;
  logic [SLOTS-1:0] inflight_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight_base <= '0;
      inflight_live <= '0;
      out_valid     <= '0;
      out_pc        <= '0;
      out_insn      <= '0;
    end else if (flush) begin
      inflight_live <= '0;
      out_valid     <= '0;
    end else if (!stall) begin
      inflight_base <= req_base;
      inflight_live <= req_live;
      out_valid     <= inflight_live;
      out_pc        <= inflight_base;
      out_insn      <= rsp_data;
    end
  end
endmodule

// File: rtl/half_fetch_unit.sv
module half_fetch_unit
  import half_fetch_pkg::*;
#(
  parameter int    INSN_BYTES = 4,
  parameter int    SLOTS      = 2,
  parameter int    INSN_W     = 32,
  parameter addr_t RESET_PC   = 32'h0000_0100,
  localparam int   IB_W       = $clog2(INSN_BYTES),
  localparam int   SLOT_W     = $clog2(SLOTS),
  localparam int   OFF_W      = IB_W + SLOT_W,
  localparam int   BLK_W      = ADDR_W - OFF_W - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    redirect_valid,
  input  logic [ADDR_W-1:0]       redirect_pc,
  input  logic                    br_taken,
  input  logic [SLOT_W-1:0]       br_slot,
  input  logic [ADDR_W-1:0]       br_target,
  output logic                    mem_en,
  output logic [BLK_W-1:0]        mem_block,
  output logic                    mem_upper,
  input  logic [SLOTS*INSN_W-1:0] mem_rdata,
  output logic [SLOTS-1:0]        out_valid,
  output logic [ADDR_W-1:0]       out_pc,
  output logic [SLOTS*INSN_W-1:0] out_insn
);
  addr_t            fetch_pc;
  addr_t            seq_pc;
  addr_t            req_half_addr;
  logic [SLOTS-1:0] req_live;
  logic             req_fire;

  fetch_pc_gen #(.OFF_W(OFF_W), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .br_taken(br_taken), .br_target(br_target),
    .fetch_pc(fetch_pc), .seq_pc(seq_pc)
  );

  fetch_slot_mask #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_mask (
    .start_slot(fetch_pc[OFF_W-1:IB_W]), .br_taken(br_taken),
    .br_slot(br_slot), .live(req_live)
  );

  assign req_half_addr = half_base(fetch_pc, OFF_W);
  assign req_fire      = !stall;
  assign mem_en        = req_fire;
  assign mem_block     = req_half_addr[ADDR_W-1:OFF_W+1];
  assign mem_upper     = req_half_addr[OFF_W];

  fetch_stage_regs #(.SLOTS(SLOTS), .INSN_W(INSN_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .stall(stall), .flush(redirect_valid),
    .req_base(req_half_addr), .req_live(req_live), .rsp_data(mem_rdata),
    .out_valid(out_valid), .out_pc(out_pc), .out_insn(out_insn)
  );
endmodule

// File: rtl/half_fetch_unit_chk.sv
module half_fetch_unit_chk
  import half_fetch_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             redirect_valid,
  input addr_t            redirect_pc,
  input logic             br_taken,
  input addr_t            br_target,
  input addr_t            req_half_addr,
  input logic [SLOTS-1:0] out_valid,
  input addr_t            out_pc
);
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect_valid && !br_taken) |=> req_half_addr == $past(req_half_addr) + (addr_t'(1) << OFF_W)); // R5
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect_valid && br_taken) |=> req_half_addr == half_base($past(br_target), OFF_W)); // R6
  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> req_half_addr == half_base($past(redirect_pc), OFF_W)); // R7
  AST_REDIRECT_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> out_valid == '0); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect_valid) |=> $stable(out_valid) && $stable(out_pc) && $stable(req_half_addr)); // R8
endmodule

bind half_fetch_unit half_fetch_unit_chk #(.SLOTS(SLOTS), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .redirect_valid(redirect_valid),
  .redirect_pc(redirect_pc), .br_taken(br_taken), .br_target(br_target),
  .req_half_addr(req_half_addr), .out_valid(out_valid), .out_pc(out_pc)
);

// File: tb/half_fetch_unit_test.sv
module half_fetch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic        st;
    logic        rd;
    logic [31:0] rpc;
    logic        bt;
    logic        bs;
    logic [31:0] btgt;
    logic        en;
    logic [31:0] req;
    logic [1:0]  val;
    logic [31:0] base;
  } vec_t;

  // One row per cycle after reset release: stimulus, then expected request and bundle.
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h100, 2'b00, 32'h0},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h108, 2'b00, 32'h0},
    '{1'b0, 1'b0, 32'h0,     1'b1, 1'b0, 32'h20C,   1'b1, 32'h110, 2'b11, 32'h100},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h208, 2'b11, 32'h108},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h210, 2'b01, 32'h110},
    '{1'b1, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b0, 32'h218, 2'b10, 32'h208},
    '{1'b1, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b0, 32'h218, 2'b10, 32'h208},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h218, 2'b10, 32'h208},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h220, 2'b11, 32'h210},
    '{1'b0, 1'b1, 32'h304,   1'b0, 1'b0, 32'h0,     1'b1, 32'h228, 2'b11, 32'h218},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h300, 2'b00, 32'h0},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h308, 2'b00, 32'h0},
    '{1'b0, 1'b0, 32'h0,     1'b1, 1'b1, 32'h400,   1'b1, 32'h310, 2'b10, 32'h300},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h400, 2'b11, 32'h308},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h408, 2'b11, 32'h310},
    '{1'b1, 1'b1, 32'h50C,   1'b0, 1'b0, 32'h0,     1'b0, 32'h410, 2'b11, 32'h400},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h508, 2'b00, 32'h0},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h510, 2'b00, 32'h0},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h518, 2'b10, 32'h508},
    '{1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 32'h0,     1'b1, 32'h520, 2'b11, 32'h510}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic        br_taken = 1'b0;
  logic [0:0]  br_slot = '0;
  logic [31:0] br_target = '0;
  logic        mem_en;
  logic [27:0] mem_block;
  logic        mem_upper;
  logic [63:0] mem_rdata = '0;
  logic [1:0]  out_valid;
  logic [31:0] out_pc;
  logic [63:0] out_insn;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  half_fetch_unit uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .br_taken(br_taken), .br_slot(br_slot),
    .br_target(br_target), .mem_en(mem_en), .mem_block(mem_block),
    .mem_upper(mem_upper), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_pc(out_pc), .out_insn(out_insn)
  );

  function automatic logic [31:0] word_at(logic [31:0] a);
    return 32'hC0DE_0000 ^ (a * 32'd7);
  endfunction

  // Memory model: one cycle read latency, data held while not enabled.
  always_ff @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= {word_at({mem_block, mem_upper, 3'b100}), word_at({mem_block, mem_upper, 3'b000})};
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 2'b00, "R1 out_valid in reset", 64'(out_valid), 64'h0);
    check({mem_block, mem_upper, 3'b000} == 32'h100, "R1 request in reset",
          64'({mem_block, mem_upper, 3'b000}), 64'h100);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      stall = TBL[k].st;
      redirect_valid = TBL[k].rd;
      redirect_pc = TBL[k].rpc;
      br_taken = TBL[k].bt;
      br_slot = TBL[k].bs;
      br_target = TBL[k].btgt;
      #1;
      // R2 request encoding, R5/R6/R7 next request, R8 enable low in stall
      check(mem_en == TBL[k].en, "R8 mem_en", 64'(mem_en), 64'(TBL[k].en));
      check({mem_block, mem_upper, 3'b000} == TBL[k].req, "R2 R5 R6 R7 request half",
            64'({mem_block, mem_upper, 3'b000}), 64'(TBL[k].req));
      check(mem_upper == TBL[k].req[3], "R2 half select", 64'(mem_upper), 64'(TBL[k].req[3]));
      // R3 R4 R6 R7 R9 bundle liveness, two edges after the request
      check(out_valid == TBL[k].val, "R4 R6 R7 R9 out_valid", 64'(out_valid), 64'(TBL[k].val));
      if (TBL[k].val != 2'b00) begin
        check(out_pc == TBL[k].base, "R3 R9 out_pc", 64'(out_pc), 64'(TBL[k].base));
        for (int s = 0; s < 2; s++) begin
          if (TBL[k].val[s]) begin
            check(out_insn[s*32 +: 32] == word_at(TBL[k].base + 32'(4 * s)), "R3 slot word",
                  64'(out_insn[s*32 +: 32]), 64'(word_at(TBL[k].base + 32'(4 * s))));
          end
        end
      end
      @(negedge clk);
    end
    stall = 1'b0;
    redirect_valid = 1'b0;
    br_taken = 1'b0;
    // R1 reset again mid-stream
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check(out_valid == 2'b00, "R1 out_valid after re-reset", 64'(out_valid), 64'h0);
    check({mem_block, mem_upper, 3'b000} == 32'h100, "R1 request after re-reset",
          64'({mem_block, mem_upper, 3'b000}), 64'h100);
    rst_n = 1'b1;
    // R6 branch in slot 0 with a target in the upper half of the next block
    br_taken = 1'b1;
    br_slot = 1'b0;
    br_target = 32'h71C;
    @(negedge clk);
    br_taken = 1'b0;
    #1;
    check({mem_block, mem_upper, 3'b000} == 32'h718, "R6 target half",
          64'({mem_block, mem_upper, 3'b000}), 64'h718);
    check(mem_upper == 1'b1, "R2 upper half of target", 64'(mem_upper), 64'h1);
    @(negedge clk);
    #1;
    check(out_valid == 2'b01, "R6 later slot killed", 64'(out_valid), 64'h1);
    check({mem_block, mem_upper, 3'b000} == 32'h720, "R5 crossing into next block",
          64'({mem_block, mem_upper, 3'b000}), 64'h720);
    @(negedge clk);
    #1;
    check(out_valid == 2'b10, "R4 slot before target killed", 64'(out_valid), 64'h2);
    check(out_pc == 32'h718, "R4 bundle base", 64'(out_pc), 64'h718);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule